// File: doc/BRIEF.md
# Two-Core Snooping Write-Invalidate Cache Pair

This block holds two private caches for a pair of processor cores that share one address space and one external main memory. Each cache is direct-mapped, holds one-word lines and writes through to memory. The two caches reach memory over a single shared bus, and an arbiter inside the block decides which cache owns it. The arbiter therefore orders every memory transaction from either core.

Each write from a core goes onto the bus as a memory write, whether it hits or misses locally. The same bus write also serves as the invalidate. The other cache watches the bus, and when a write completes it drops any copy it holds of that word. A later read of that word by the other core misses and fetches the new value.

A core holds its request steady until the cache raises a one-cycle completion pulse. The external memory takes a request and answers with a one-cycle acknowledge after any latency.

Top module: `snoop_coh_pair`

## Requirements
- R1: After reset neither core sees a completion, the memory request is low, and every line is invalid, so the first read of any address misses.
- R2: A read miss issues one memory read for the word and returns its data with hit=0. A repeat read of the same word returns the data with hit=1 and issues no memory transaction.
- R3: The line index is address bits [5:2], the tag is the bits above them, and address bits [1:0] are ignored. A read to the same index with a different tag misses and replaces the line.
- R4: Every write issues one memory write carrying the address and data, and memory holds the new data. A write that hits updates the local copy. A write that misses does not allocate a line.
- R5: When a write from one core completes on the bus, the other cache invalidates a matching line. That core's next read misses and returns the written value.
- R6: A cache's own bus write never invalidates its own line. A read after its own write hits and returns the new data.
- R7: A snooped write to the same index with a different tag leaves the line valid.
- R8: When both caches ask for the bus in the same cycle, the core that did not win the last grant goes first; after reset that is core 0. The owner keeps the memory request, address, direction and data stable until the acknowledge arrives.
- R9: If a write by the other core to the word a read miss is waiting for completes before that miss finishes, the miss does not install the fetched word. It issues a second memory read and returns that result.
- R10: The completion output is a single-cycle pulse. Read data and hit are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req | input | 1 | Core 0 request, held until c0_done |
| c0_we | input | 1 | Core 0 write (1) or read (0) |
| c0_addr | input | AW | Core 0 byte address |
| c0_wdata | input | DW | Core 0 write data |
| c0_done | output | 1 | Core 0 completion pulse |
| c0_hit | output | 1 | Core 0 read served from its cache |
| c0_rdata | output | DW | Core 0 read data |
| c1_req | input | 1 | Core 1 request, held until c1_done |
| c1_we | input | 1 | Core 1 write (1) or read (0) |
| c1_addr | input | AW | Core 1 byte address |
| c1_wdata | input | DW | Core 1 write data |
| c1_done | output | 1 | Core 1 completion pulse |
| c1_hit | output | 1 | Core 1 read served from its cache |
| c1_rdata | output | DW | Core 1 read data |
| mem_req | output | 1 | Shared bus transaction to memory active |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | AW | Transaction byte address |
| mem_wdata | output | DW | Transaction write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |

## Verification
The bench builds the block with its defaults: an 8-bit address, 32-bit data and 16 lines. That gives a 64-word memory, and each of the 16 indices has four possible tags. Sweeps can therefore fill and re-read every line of a cache. They can also reach every index with a conflicting tag, and the bench can compute each expected word from the address. A bench memory with a two-cycle latency keeps a waiting requester pending while the other core's write finishes. This opens the simultaneous-request ordering and the stale-refill window to directed checks.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int NCORE = 2;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_BUS  = 2'd1,
    C_RESP = 2'd2
  } cache_st_t;
endpackage

// File: rtl/bus_arbiter.sv
module bus_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       ack,
  output logic [1:0] gnt,
  output logic       busy,
  output logic       owner
);
  logic prio;
  logic pick;

  // the core that did not win the last grant is preferred
  assign pick = req[prio] ? prio : ~prio;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= 1'b0;
      prio  <= 1'b0;
    end else if (!busy) begin
      if (|req) begin
        busy  <= 1'b1;
        owner <= pick;
        prio  <= ~pick;
      end
    end else if (ack) begin
      busy <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_gnt
    assign gnt[gi] = busy && (owner == 1'(gi));
  end
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_done,
  output logic          cpu_hit,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_wr,
  input  logic [AW-1:0] snp_addr,
  output logic          inv_evt,
  output logic          retry_evt
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW - 2;

  function automatic logic [IW-1:0] idx_of(input logic [AW-1:0] a);
    return a[IW+1:2];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IW+2];
  endfunction

  function automatic logic same_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (idx_of(a) == idx_of(b)) && (tag_of(a) == tag_of(b));
  endfunction

  cache_st_t     st;
  logic [LINES-1:0] vld;
  logic [TW-1:0] tags [LINES];
  logic [DW-1:0] dat  [LINES];

  logic          p_we;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic          stale;
  logic          hit_q;
  logic [DW-1:0] rdata_q;

  logic [IW-1:0] lk_idx, s_idx, p_idx;
  logic          lk_hit, s_hit, p_hit, pend_match, xfer_done;

  assign lk_idx     = idx_of(cpu_addr);
  assign lk_hit     = vld[lk_idx] && (tags[lk_idx] == tag_of(cpu_addr));
  assign s_idx      = idx_of(snp_addr);
  assign s_hit      = snp_wr && vld[s_idx] && (tags[s_idx] == tag_of(snp_addr));
  assign p_idx      = idx_of(p_addr);
  assign p_hit      = vld[p_idx] && (tags[p_idx] == tag_of(p_addr));
  assign pend_match = snp_wr && (st == C_BUS) && !p_we && same_word(snp_addr, p_addr);
  assign xfer_done  = (st == C_BUS) && bus_gnt && bus_ack;

  assign inv_evt   = s_hit;
  assign retry_evt = xfer_done && !p_we && stale;

  assign cpu_done  = (st == C_RESP);
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = (st == C_BUS);
  assign bus_we    = p_we;
  assign bus_addr  = p_addr;
  assign bus_wdata = p_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      vld     <= '0;
      p_we    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
      stale   <= 1'b0;
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (s_hit) vld[s_idx] <= 1'b0;
      if (pend_match) stale <= 1'b1;
      unique case (st)
        C_IDLE: begin
          if (cpu_req) begin
            p_we    <= cpu_we;
            p_addr  <= cpu_addr;
            p_wdata <= cpu_wdata;
            stale   <= 1'b0;
            if (!cpu_we && lk_hit) begin
              rdata_q <= dat[lk_idx];
              hit_q   <= 1'b1;
              st      <= C_RESP;
            end else begin
              hit_q <= 1'b0;
              st    <= C_BUS;
            end
          end
        end
        C_BUS: begin
          if (xfer_done) begin
            if (p_we) begin
              if (p_hit) dat[p_idx] <= p_wdata;
              st <= C_RESP;
            end else if (stale) begin
              stale <= 1'b0;
              st    <= C_BUS;
            end else begin
              vld[p_idx]  <= 1'b1;
              tags[p_idx] <= tag_of(p_addr);
              dat[p_idx]  <= bus_rdata;
              rdata_q     <= bus_rdata;
              st          <= C_RESP;
            end
          end
        end
        C_RESP:  st <= C_IDLE;
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_coh_pair.sv
module snoop_coh_pair
  import coh_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c0_req,
  input  logic          c0_we,
  input  logic [AW-1:0] c0_addr,
  input  logic [DW-1:0] c0_wdata,
  output logic          c0_done,
  output logic          c0_hit,
  output logic [DW-1:0] c0_rdata,
  input  logic          c1_req,
  input  logic          c1_we,
  input  logic [AW-1:0] c1_addr,
  input  logic [DW-1:0] c1_wdata,
  output logic          c1_done,
  output logic          c1_hit,
  output logic [DW-1:0] c1_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic [NCORE-1:0] c_req, c_we, c_done, c_hit;
  logic [AW-1:0]    c_addr [NCORE];
  logic [DW-1:0]    c_wd   [NCORE];
  logic [DW-1:0]    c_rd   [NCORE];

  logic [NCORE-1:0] bus_req, b_we, gnt, snp_wr, inv_evt, retry_evt;
  logic [AW-1:0]    b_addr [NCORE];
  logic [DW-1:0]    b_wd   [NCORE];
  logic             busy, owner;

  assign c_req     = {c1_req, c0_req};
  assign c_we      = {c1_we, c0_we};
  assign c_addr[0] = c0_addr;
  assign c_addr[1] = c1_addr;
  assign c_wd[0]   = c0_wdata;
  assign c_wd[1]   = c1_wdata;
  assign c0_done   = c_done[0];
  assign c1_done   = c_done[1];
  assign c0_hit    = c_hit[0];
  assign c1_hit    = c_hit[1];
  assign c0_rdata  = c_rd[0];
  assign c1_rdata  = c_rd[1];

  bus_arbiter arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (bus_req),
    .ack   (mem_ack),
    .gnt   (gnt),
    .busy  (busy),
    .owner (owner)
  );

  for (genvar gi = 0; gi < NCORE; gi++) begin : g_core
    // a completed bus write by the other core is the invalidate
    assign snp_wr[gi] = busy && mem_ack && mem_we && (owner != 1'(gi));

    wt_cache #(.AW(AW), .DW(DW), .LINES(LINES)) cache_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (c_req[gi]),
      .cpu_we    (c_we[gi]),
      .cpu_addr  (c_addr[gi]),
      .cpu_wdata (c_wd[gi]),
      .cpu_done  (c_done[gi]),
      .cpu_hit   (c_hit[gi]),
      .cpu_rdata (c_rd[gi]),
      .bus_req   (bus_req[gi]),
      .bus_we    (b_we[gi]),
      .bus_addr  (b_addr[gi]),
      .bus_wdata (b_wd[gi]),
      .bus_gnt   (gnt[gi]),
      .bus_ack   (mem_ack),
      .bus_rdata (mem_rdata),
      .snp_wr    (snp_wr[gi]),
      .snp_addr  (mem_addr),
      .inv_evt   (inv_evt[gi]),
      .retry_evt (retry_evt[gi])
    );
  end

  assign mem_req   = busy;
  assign mem_we    = busy && b_we[owner];
  assign mem_addr  = b_addr[owner];
  assign mem_wdata = b_wd[owner];
endmodule

// File: rtl/coh_checker.sv
module coh_checker #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    gnt,
  input logic [1:0]    bus_req,
  input logic          owner,
  input logic [1:0]    inv_evt,
  input logic [1:0]    retry_evt,
  input logic          c0_done,
  input logic          c1_done,
  input logic          c0_hit,
  input logic          c1_hit,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R8
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8
  AST_INV0_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) inv_evt[0] |-> (mem_ack && mem_we && owner)); // R5
  AST_INV1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) inv_evt[1] |-> (mem_ack && mem_we && !owner)); // R6
  AST_DONE0_PULSE: assert property (@(posedge clk) disable iff (!rst_n) c0_done |=> !c0_done); // R10
  AST_DONE1_PULSE: assert property (@(posedge clk) disable iff (!rst_n) c1_done |=> !c1_done); // R10
  AST_HIT0_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) (c0_done && c0_hit) |-> !$past(gnt[0])); // R2
  AST_HIT1_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) (c1_done && c1_hit) |-> !$past(gnt[1])); // R2
  AST_RETRY0_REISSUE: assert property (@(posedge clk) disable iff (!rst_n) retry_evt[0] |=> bus_req[0]); // R9
  AST_RETRY1_REISSUE: assert property (@(posedge clk) disable iff (!rst_n) retry_evt[1] |=> bus_req[1]); // R9
endmodule

bind snoop_coh_pair coh_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .gnt       (gnt),
  .bus_req   (bus_req),
  .owner     (owner),
  .inv_evt   (inv_evt),
  .retry_evt (retry_evt),
  .c0_done   (c0_done),
  .c1_done   (c1_done),
  .c0_hit    (c0_hit),
  .c1_hit    (c1_hit),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/snoop_coh_pair_tb.sv
`timescale 1ns/1ps
module snoop_coh_pair_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LAT = 2;
  localparam int WORDS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          b_req [2];
  logic          b_we  [2];
  logic [AW-1:0] b_addr[2];
  logic [DW-1:0] b_wd  [2];
  logic c0_done, c1_done, c0_hit, c1_hit;
  logic [DW-1:0] c0_rdata, c1_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  snoop_coh_pair #(.AW(AW), .DW(DW), .LINES(16)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .c0_req(b_req[0]), .c0_we(b_we[0]), .c0_addr(b_addr[0]), .c0_wdata(b_wd[0]),
    .c0_done(c0_done), .c0_hit(c0_hit), .c0_rdata(c0_rdata),
    .c1_req(b_req[1]), .c1_we(b_we[1]), .c1_addr(b_addr[1]), .c1_wdata(b_wd[1]),
    .c1_done(c1_done), .c1_hit(c1_hit), .c1_rdata(c1_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  // bench memory, transaction log and expected-memory shadow
  logic [DW-1:0] mem   [WORDS];
  logic [DW-1:0] exp_m [WORDS];
  logic          log_we  [1024];
  logic [AW-1:0] log_addr[1024];
  int log_n = 0;
  int lat_cnt = 0;

  function automatic logic [DW-1:0] init_word(input int k);
    return 32'hA000_0000 + 32'(k) * 32'h0000_0101;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      lat_cnt++;
      if (lat_cnt >= LAT) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[AW-1:2]];
        if (mem_we) mem[mem_addr[AW-1:2]] = mem_wdata;
        log_we[log_n]   = mem_we;
        log_addr[log_n] = mem_addr;
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int c = 0; c < 2; c++) begin
      b_req[c] = 1'b0; b_we[c] = 1'b0; b_addr[c] = '0; b_wd[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic core_op(input int c, input logic we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd, output logic ht);
    @(negedge clk);
    b_req[c] = 1'b1; b_we[c] = we; b_addr[c] = a; b_wd[c] = d;
    do @(negedge clk); while (!((c == 0) ? c0_done : c1_done));
    rd = (c == 0) ? c0_rdata : c1_rdata;
    ht = (c == 0) ? c0_hit : c1_hit;
    b_req[c] = 1'b0;
    if (we) exp_m[a[AW-1:2]] = d;
  endtask

  // read and compare in one step
  task automatic rd_chk(input int c, input logic [AW-1:0] a, input logic exp_hit, input string rq);
    logic [DW-1:0] rd; logic ht;
    core_op(c, 1'b0, a, '0, rd, ht);
    chk(rd == exp_m[a[AW-1:2]], rq, $sformatf("core%0d read data @%0h", c, a), rd, exp_m[a[AW-1:2]]);
    chk(ht == exp_hit, rq, $sformatf("core%0d hit @%0h", c, a), 32'(ht), 32'(exp_hit));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd, rd1; logic ht, ht1; int base;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int k = 0; k < WORDS; k++) begin mem[k] = init_word(k); exp_m[k] = init_word(k); end
    do_reset();

    // R1: quiet outputs after reset
    @(negedge clk);
    chk(!c0_done && !c1_done, "R1", "done after reset", {c1_done, c0_done}, 0);
    chk(!mem_req, "R1", "mem_req after reset", 32'(mem_req), 0);

    // R1/R2: first read misses with one bus read, second hits with none
    base = log_n;
    rd_chk(0, 8'h00, 1'b0, "R1");
    chk(log_n - base == 1 && !log_we[base], "R2", "one bus read on miss", log_n - base, 1);
    base = log_n;
    rd_chk(0, 8'h00, 1'b1, "R2");
    chk(log_n == base, "R2", "no bus traffic on hit", log_n - base, 0);

    // R10: completion lasts one cycle
    @(negedge clk);
    chk(!c0_done, "R10", "done is a pulse", 32'(c0_done), 0);

    // R3: low bits ignored, conflicting tag replaces
    rd_chk(0, 8'h03, 1'b1, "R3");
    rd_chk(0, 8'h40, 1'b0, "R3");
    rd_chk(0, 8'h00, 1'b0, "R3");

    // R2/R3 sweep: core 1 fills every index, then re-reads, then evicts with tag 3
    for (int i = 0; i < 16; i++) rd_chk(1, 8'(i * 4), 1'b0, "R2");
    for (int i = 0; i < 16; i++) rd_chk(1, 8'(i * 4 + 1), 1'b1, "R3");
    for (int i = 0; i < 16; i++) rd_chk(1, 8'(8'hC0 + i * 4), 1'b0, "R3");

    // R4/R6: write hit goes to memory and updates own copy
    base = log_n;
    core_op(0, 1'b1, 8'h00, 32'h1234_5678, rd, ht);
    chk(log_n - base == 1 && log_we[base] && log_addr[base] == 8'h00, "R4", "bus write issued", log_addr[base], 8'h00);
    chk(mem[0] == 32'h1234_5678, "R4", "memory updated", mem[0], 32'h1234_5678);
    rd_chk(0, 8'h00, 1'b1, "R6");
    // R4: write miss does not allocate
    core_op(0, 1'b1, 8'h84, 32'hCAFE_0084, rd, ht);
    chk(mem[8'h84 >> 2] == 32'hCAFE_0084, "R4", "memory updated on write miss", mem[8'h84 >> 2], 32'hCAFE_0084);
    rd_chk(0, 8'h84, 1'b0, "R4");

    // R5: shared-word scenario
    mem[8] = 0; exp_m[8] = 0;
    do_reset();
    rd_chk(0, 8'h20, 1'b0, "R5");
    rd_chk(1, 8'h20, 1'b0, "R5");
    core_op(0, 1'b1, 8'h20, 32'h1, rd, ht);
    rd_chk(1, 8'h20, 1'b0, "R5");
    rd_chk(0, 8'h20, 1'b1, "R6");
    rd_chk(1, 8'h20, 1'b1, "R5");

    // R7: snooped write with a different tag keeps the line
    rd_chk(1, 8'h24, 1'b0, "R7");
    core_op(0, 1'b1, 8'h64, 32'h7777_0064, rd, ht);
    rd_chk(1, 8'h24, 1'b1, "R7");

    // R8: simultaneous requests, core 0 first after reset
    do_reset();
    base = log_n;
    fork
      core_op(0, 1'b0, 8'h08, '0, rd, ht);
      core_op(1, 1'b0, 8'h0C, '0, rd1, ht1);
    join
    chk(log_addr[base] == 8'h08 && log_addr[base + 1] == 8'h0C, "R8", "first grant after reset", log_addr[base], 8'h08);
    chk(rd == exp_m[2] && rd1 == exp_m[3], "R8", "both reads correct", rd1, exp_m[3]);
    core_op(0, 1'b0, 8'h10, '0, rd, ht);
    base = log_n;
    fork
      core_op(0, 1'b0, 8'h14, '0, rd, ht);
      core_op(1, 1'b0, 8'h18, '0, rd1, ht1);
    join
    chk(log_addr[base] == 8'h18, "R8", "core 1 first after core 0 grant", log_addr[base], 8'h18);

    // R9: write from core 0 lands while core 1 waits to refill the same word
    do_reset();
    base = log_n;
    fork
      core_op(0, 1'b1, 8'h30, 32'h5A5A_0030, rd, ht);
      core_op(1, 1'b0, 8'h30, '0, rd1, ht1);
    join
    chk(rd1 == 32'h5A5A_0030, "R9", "refill returns written value", rd1, 32'h5A5A_0030);
    chk(log_n - base == 3, "R9", "bus transactions incl. retry", log_n - base, 3);
    chk(log_we[base] && !log_we[base + 1] && !log_we[base + 2], "R9", "write then two reads",
        {29'b0, log_we[base], log_we[base + 1], log_we[base + 2]}, 3'b100);
    rd_chk(1, 8'h30, 1'b1, "R9");

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule